// File: doc/BRIEF.md
# Half-Word Access Mailbox Queue

This block is a single-channel message queue between two processors. A sender writes 32-bit messages into a message register. A receiver reads them back in arrival order from the same register. A level interrupt tells the receiver that at least one message is waiting. A status register reports how many entries are in the queue, whether it is full, and whether a message was lost. An enable register gates the interrupt.

The register port accepts 32-bit accesses and 16-bit accesses. A processor with a 16-bit bus moves a message as two half-word accesses, lower half first. The lower half only goes to a staging register (on a write) or is looked at without consuming it (on a read). The queue push or pop, the status change and any interrupt change all happen on the upper half-word access. The status and enable registers take each half-word on its own, in any order.

The port is a plain register port, not a stream. Every access is accepted in the cycle it is presented and there is no back-pressure. A full queue drops the write and records the loss. Read data is registered and appears one cycle after the read strobe. Read and write strobes are not meant to be raised together; if they are, the write takes effect and the read is ignored.

Top module: `hw_mailbox`

## Requirements
- R1: A 32-bit write to the message register (byte address 0x0) appends `bus_wdata` to the queue. A 32-bit read of it returns the oldest entry on `bus_rdata` one cycle after the strobe and removes that entry. Entries come out in the order they were written.
- R2: A 16-bit access (`bus_half`=1) uses address bit 1 to pick the half-word: 0 selects bits 15:0 and 1 selects bits 31:16. Write data is taken from `bus_wdata[15:0]`. Read data is returned in `bus_rdata[15:0]` with bits 31:16 zero. The status and enable registers take half-word accesses independently. Their upper halves read as zero, and writes to their upper halves change nothing.
- R3: A 16-bit write to address 0x2 appends the word {`bus_wdata[15:0]`, staged low bits} to the queue.
- R4: A 16-bit write to address 0x0 only loads the staging register. The queue, the status and `irq_msg` are unchanged.
- R5: A 16-bit read at 0x0 returns bits 15:0 of the oldest entry and does not remove it. A 16-bit read at 0x2 returns bits 31:16 of the oldest entry and removes it.
- R6: Any read of the message register while the queue is empty returns zero and leaves the queue unchanged.
- R7: A write that would append to a full queue (4 entries by default) is dropped and sets a sticky overflow flag.
- R8: The status register at 0x4 holds the entry count in bits 2:0, full in bit 3 and overflow in bit 4. A 32-bit write, or a 16-bit write at 0x4, with bit 4 set clears the overflow flag. No other status bit can be written.
- R9: The enable register at 0x8 holds the interrupt enable in bit 0. `irq_msg` is high exactly while that bit is set and the queue holds at least one entry.
- R10: An upper-half message write with no lower-half write before it uses the most recently staged low bits, which are zero after reset. The staged bits are kept after a commit.
- R11: After reset the queue is empty, overflow, enable and staging are zero, and `bus_rdata` and `irq_msg` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_half | input | 1 | 1 for a 16-bit access, 0 for a 32-bit access |
| bus_wdata | input | 32 | Write data; for 16-bit accesses only bits 15:0 are used |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_msg | output | 1 | Level interrupt: message waiting and enabled |

## Verification
The bench builds the block with its default depth of 4 entries and 32-bit words. At that depth a handful of writes reaches the full boundary, so the dropped fifth write, the sticky overflow and its clearing through a lower-half status write are all tested. With a short queue, the wrap of the read and write pointers is also exercised during the drain. A mid-run reset shows that staged bits return to zero, and commits of an upper half alone then show both the zero default and the reuse of staged bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    SEL_MSG  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IE   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status register field layout
  localparam int ST_CNT_W    = 3;
  localparam int ST_FULL_BIT = 3;
  localparam int ST_OVF_BIT  = 4;
  localparam int IE_BIT      = 0;

  typedef struct packed {
    reg_sel_e sel;
    logic     wr;     // write accepted
    logic     rd;     // read accepted (not shadowed by a write)
    logic     upper;  // half access to bits 31:16
    logic     half;   // 16-bit access
  } acc_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  logic [3:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic       half,
  output acc_t       acc
);

  reg_sel_e sel;

  always_comb begin
    unique case (addr[3:2])
      2'd0:    sel = SEL_MSG;
      2'd1:    sel = SEL_STAT;
      2'd2:    sel = SEL_IE;
      default: sel = SEL_NONE;
    endcase
    // odd byte addresses and upper-half addresses of 32-bit accesses are not decoded
    if (addr[0] || (!half && addr[1])) sel = SEL_NONE;
  end

  always_comb begin
    acc.sel   = sel;
    acc.wr    = wr;
    acc.rd    = rd && !wr;
    acc.half  = half;
    acc.upper = half && addr[1];
  end

endmodule

// File: rtl/mbox_stage.sv
module mbox_stage
  import mbox_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] wdata,
  output logic          push,
  output logic          pop,
  output logic [DW-1:0] push_data
);

  localparam int HW = DW / 2;

  logic [HW-1:0] low_q;
  logic          msg_hit;
  logic          commit_edge;

  assign msg_hit     = (acc.sel == SEL_MSG);
  // only the upper half (or a whole word) touches the queue
  assign commit_edge = !acc.half || acc.upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (acc.wr && msg_hit && acc.half && !acc.upper) begin
      low_q <= wdata[HW-1:0];
    end
  end

  assign push      = acc.wr && msg_hit && commit_edge;
  assign pop       = acc.rd && msg_hit && commit_edge;
  assign push_data = acc.half ? {wdata[HW-1:0], low_q} : wdata;

endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (do_push && wp == PW'(i)) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/hw_mailbox.sv
module hw_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_half,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_msg
);

  localparam int DW = 32;
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DEPTH + 1);

  acc_t          acc;
  logic          push, pop;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] fill;
  logic          full, empty;
  logic          ovf_q, ie_q;
  logic          low_wr;
  logic [DW-1:0] word, rd_next;

  mbox_decode u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .half (bus_half),
    .acc  (acc)
  );

  mbox_stage #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wdata     (bus_wdata),
    .push      (push),
    .pop       (pop),
    .push_data (push_data)
  );

  mbox_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .head      (head),
    .count     (fill),
    .full      (full),
    .empty     (empty)
  );

  // writes that reach bits 15:0 of a register
  assign low_wr = acc.wr && !acc.upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (push && full) ovf_q <= 1'b1;
      else if (low_wr && acc.sel == SEL_STAT && bus_wdata[ST_OVF_BIT]) ovf_q <= 1'b0;
      if (low_wr && acc.sel == SEL_IE) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    word = '0;
    unique case (acc.sel)
      SEL_MSG:  word = empty ? '0 : head;
      SEL_STAT: begin
        word[ST_CNT_W-1:0] = ST_CNT_W'(fill);
        word[ST_FULL_BIT]  = full;
        word[ST_OVF_BIT]   = ovf_q;
      end
      SEL_IE:   word[IE_BIT] = ie_q;
      default:  word = '0;
    endcase
    if (!acc.half)      rd_next = word;
    else if (acc.upper) rd_next = {{HW{1'b0}}, word[DW-1:HW]};
    else                rd_next = {{HW{1'b0}}, word[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (acc.rd) bus_rdata <= rd_next;
  end

  assign irq_msg = ie_q && !empty;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_half,
  input logic [31:0]   bus_rdata,
  input logic          irq_msg,
  input logic [CW-1:0] fill,
  input logic          ovf
);

  // R4: a lower-half message write leaves fill and interrupt alone
  a_r4_low_write_stages: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_half && bus_addr == 4'h0) |=> ($stable(fill) && $stable(irq_msg)));

  // R5: a lower-half message read does not pop
  a_r5_low_read_peeks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_half && bus_addr == 4'h0) |=> $stable(fill));

  // R3: an upper-half message write with room adds one entry
  a_r3_upper_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_half && bus_addr == 4'h2 && fill < CW'(DEPTH)) |=> (fill == $past(fill) + 1'b1));

  // R7: a write to a full queue is dropped and flags overflow
  a_r7_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_half && bus_addr == 4'h0 && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH) && ovf));

  // R6: reading an empty queue yields zero
  a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr[3:2] == 2'd0 && fill == '0) |=> (bus_rdata == 32'h0 && fill == '0));

  // R9: no interrupt without a waiting message
  a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg |-> (fill != '0));

  // R7: occupancy never exceeds the depth
  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

bind hw_mailbox mbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_half  (bus_half),
  .bus_rdata (bus_rdata),
  .irq_msg   (irq_msg),
  .fill      (fill),
  .ovf       (ovf_q)
);

// File: tb/test_hw_mailbox.sv
module test_hw_mailbox;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_half = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_msg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hw_mailbox #(.DEPTH(4)) i_hw_mailbox (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_half,
    .bus_wdata, .bus_rdata, .irq_msg
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        half;
    logic [3:0]  addr;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,4'h8,32'h1,       0,32'h0,       0,4'd9},  // R9 enable, queue empty
    '{1,0,1,4'h0,32'h1111,    0,32'h0,       0,4'd4},  // R4 stage low
    '{0,1,0,4'h4,32'h0,       1,32'h0,       0,4'd4},  // R4 count still 0
    '{1,0,1,4'h2,32'h2222,    0,32'h0,       1,4'd3},  // R3 upper commits
    '{0,1,0,4'h4,32'h0,       1,32'h1,       1,4'd8},  // R8 count 1
    '{1,0,0,4'h0,32'hAABBCCDD,0,32'h0,       1,4'd1},  // R1 word write
    '{0,1,1,4'h0,32'h0,       1,32'h1111,    1,4'd5},  // R5 peek low
    '{0,1,0,4'h4,32'h0,       1,32'h2,       1,4'd5},  // R5 no pop
    '{0,1,1,4'h2,32'h0,       1,32'h2222,    1,4'd5},  // R5 upper pops
    '{0,1,0,4'h4,32'h0,       1,32'h1,       1,4'd5},  // R5 count 1
    '{0,1,0,4'h0,32'h0,       1,32'hAABBCCDD,0,4'd1},  // R1 word read
    '{0,1,0,4'h0,32'h0,       1,32'h0,       0,4'd6},  // R6 empty read
    '{0,1,0,4'h4,32'h0,       1,32'h0,       0,4'd6},  // R6 still empty
    '{1,0,0,4'h0,32'h10,      0,32'h0,       1,4'd1},  // R1 fill
    '{1,0,0,4'h0,32'h11,      0,32'h0,       1,4'd1},  // R1
    '{1,0,0,4'h0,32'h12,      0,32'h0,       1,4'd1},  // R1
    '{1,0,0,4'h0,32'h13,      0,32'h0,       1,4'd1},  // R1
    '{0,1,0,4'h4,32'h0,       1,32'hC,       1,4'd8},  // R8 count 4 + full
    '{1,0,0,4'h0,32'h99,      0,32'h0,       1,4'd7},  // R7 dropped
    '{0,1,0,4'h4,32'h0,       1,32'h1C,      1,4'd7},  // R7 overflow set
    '{1,0,1,4'h6,32'h10,      0,32'h0,       1,4'd2},  // R2 upper status write
    '{0,1,0,4'h4,32'h0,       1,32'h1C,      1,4'd2},  // R2 no change
    '{0,1,1,4'h6,32'h0,       1,32'h0,       1,4'd2},  // R2 upper status reads 0
    '{1,0,1,4'h4,32'h10,      0,32'h0,       1,4'd8},  // R8 clear overflow
    '{0,1,0,4'h4,32'h0,       1,32'hC,       1,4'd8},  // R8 cleared
    '{1,0,1,4'hA,32'h0,       0,32'h0,       1,4'd2},  // R2 upper enable write ignored
    '{0,1,0,4'h8,32'h0,       1,32'h1,       1,4'd2},  // R2 enable still 1
    '{1,0,1,4'h8,32'h0,       0,32'h0,       0,4'd9},  // R9 disable masks irq
    '{0,1,0,4'h0,32'h0,       1,32'h10,      0,4'd1},  // R1 order
    '{0,1,0,4'h0,32'h0,       1,32'h11,      0,4'd1},  // R1
    '{0,1,1,4'h0,32'h0,       1,32'h12,      0,4'd5},  // R5 peek
    '{0,1,1,4'h2,32'h0,       1,32'h0,       0,4'd5},  // R5 upper of 0x12, pop
    '{0,1,0,4'h0,32'h0,       1,32'h13,      0,4'd1},  // R1 wrap
    '{0,1,0,4'h0,32'h0,       1,32'h0,       0,4'd7},  // R7 0x99 lost
    '{0,1,0,4'h4,32'h0,       1,32'h0,       0,4'd6}   // R6 empty again
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic half,
                        input logic [3:0] addr, input logic [31:0] wd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_half = half; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_half = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 rdata", bus_rdata, 32'h0);
    check("R11 irq", {31'b0, irq_msg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].rd, VECS[i].half, VECS[i].addr, VECS[i].wd);
      if (VECS[i].chk)
        check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp);
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, irq_msg}, {31'b0, VECS[i].irq});
    end

    // R11: reset with data queued and a value staged
    access(1, 0, 0, 4'h8, 32'h1);
    access(1, 0, 1, 4'h0, 32'h7777);
    access(1, 0, 0, 4'h0, 32'h5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 irq after reset", {31'b0, irq_msg}, 32'h0);
    check("R11 rdata after reset", bus_rdata, 32'h0);
    access(0, 1, 0, 4'h4, 32'h0);
    check("R11 status after reset", bus_rdata, 32'h0);
    access(0, 1, 0, 4'h8, 32'h0);
    check("R11 enable after reset", bus_rdata, 32'h0);

    // R10: upper half alone uses zero staged bits after reset
    access(1, 0, 1, 4'h2, 32'hBEEF);
    access(0, 1, 0, 4'h0, 32'h0);
    check("R10 zero low", bus_rdata, 32'hBEEF0000);
    // R10: staged bits persist across commits
    access(1, 0, 1, 4'h0, 32'h5555);
    access(1, 0, 1, 4'h2, 32'h0001);
    access(1, 0, 1, 4'h2, 32'h0002);
    access(0, 1, 0, 4'h0, 32'h0);
    check("R10 first", bus_rdata, 32'h00015555);
    access(0, 1, 0, 4'h0, 32'h0);
    check("R10 reused low", bus_rdata, 32'h00025555);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule